// File: doc/BRIEF.md
# Chained Display Timing Waveform Generator

This block builds the timing waveforms of a raster display from a bank of eight programmable counters. Each counter steps on a selectable trigger: nothing, a pixel tick from the surrounding pixel clock enable, or the one-cycle tick of any counter in the bank. Chaining counters this way yields the usual set of waveforms. A line tick counts pixels. A horizontal sync level steps with the line. A vertical sync level counts lines. A line-active window starts after the vertical blanking. A pixel-active window restarts on every active line.

Every counter has a period, a start delay counted on its own trigger, an optional limit on the number of periods, a trigger that restarts its sequence, and an optional level mode with programmable assert and release points. A small write-only register port loads each counter. The port rejects a whole word if any field is out of range. A general word sets a per-output inversion mask and picks which outputs drive the two sync pins. All counters are held at their start point while the enable input is low, so every offset is measured from the same released edge.

Top module: `sync_wave_gen`

## Requirements
- R1: Trigger codes are 0 = none, 1 = pixel tick, and 2+k = the tick of counter k. A counter with zero offset that steps on pixel ticks emits a one-cycle tick every run+1 events. Its first tick comes on the first pixel tick sampled while enabled. A tick sampled at edge n is visible on wave_o after edge n.
- R2: A counter stepping on counter k's tick samples that tick one edge after it appears, so each chained stage adds one cycle of latency. It then ticks once per run+1 such events.
- R3: With an offset of N on its offset trigger, a counter makes no step until N offset events have been counted. Its first tick comes on the first step event after that.
- R4: A nonzero repeat limit R stops the counter at the end of its R-th period, and no further ticks follow. A limit of 0 makes the counter run without end.
- R5: A clear-trigger event returns the counter to the start of its offset phase, with its repeat count reset. The clear takes priority over stepping, so the cycle after it shows no tick and an inactive level.
- R6: With level mode on, wave_o follows a level instead of the tick. At each step event at period position p the level becomes 1 when up <= 2p < down and 0 otherwise, and it holds until the next step event. Edges are counted in half trigger periods.
- R7: The general word sits at address 4*8 = 32. It holds the inversion mask in bits [7:0], the horizontal sync select in [10:8] and the vertical sync select in [14:12]. pin_o[k] is wave_o[k] inverted when mask bit k is set. hsync_o and vsync_o copy the selected pin_o bit.
- R8: Counter k word w sits at address 4k+w. Word 0 holds run in [15:0] and offset in [31:16], each below 4096. Word 1 holds repeat in [15:0], step trigger [19:16], offset trigger [23:16+4+3 downto 20] i.e. [23:20], clear trigger [27:24], level enable [28], and bits [31:29] must be zero. Word 2 holds up in [15:0] and down in [31:16], each below 1024. A write with any field out of range, any trigger code above 9, or any set reserved bit leaves the whole word unchanged.
- R9: After reset, and on the edge after any cycle with en_i low, every counter sits at its start point with wave_o all zero. Raising en_i releases all counters on the same edge.
- R10: A counter whose step trigger is none never ticks and drives an inactive wave_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Releases the counter bank when high |
| pix_tick_i | input | 1 | One pixel event per cycle in which it is high |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 6 | Configuration word address |
| cfg_wdata_i | input | 32 | Configuration write data |
| wave_o | output | 8 | Raw waveform of each counter (tick or level) |
| pin_o | output | 8 | Waveforms after per-output inversion |
| hsync_o | output | 1 | Selected horizontal sync pin |
| vsync_o | output | 1 | Selected vertical sync pin |

## Verification
The bound checker watches four properties on every cycle: the bank goes quiet after a disabled cycle, a counter with no step trigger never ticks, a clear event wins over stepping, and an out-of-range write leaves the target fields untouched. The exact tick positions need whole scenarios, which only the bench can run. These are the period of a pixel counter, the one-cycle latency of a chained stage, the delay of an offset, the stop after a repeat limit, the width and placement of a level window, and the inversion and routing of the sync pins. The bench also checks that a rejected word cannot enable an idle counter while a valid one does.

// File: rtl/sync_gen_pkg.sv
package sync_gen_pkg;

    localparam int SG_NCTR   = 8;
    localparam int SG_RUN_W  = 12;
    localparam int SG_REP_W  = 16;
    localparam int SG_EDGE_W = 10;
    localparam int SG_DATA_W = 32;

    localparam int SG_NSRC     = SG_NCTR + 2;
    localparam int SG_SRC_W    = $clog2(SG_NSRC);
    localparam int SG_SEL_W    = $clog2(SG_NCTR);
    localparam int SG_GEN_ADDR = 4 * SG_NCTR;
    localparam int SG_ADDR_W   = $clog2(SG_GEN_ADDR + 1);

    typedef struct packed {
        logic [SG_RUN_W-1:0]  run_cnt;
        logic [SG_RUN_W-1:0]  off_cnt;
        logic [SG_REP_W-1:0]  rep_cnt;
        logic [SG_SRC_W-1:0]  run_src;
        logic [SG_SRC_W-1:0]  off_src;
        logic [SG_SRC_W-1:0]  clr_src;
        logic                 lvl_en;
        logic [SG_EDGE_W-1:0] up_pos;
        logic [SG_EDGE_W-1:0] dn_pos;
    } ctr_cfg_t;

    typedef struct packed {
        logic [SG_NCTR-1:0]  inv;
        logic [SG_SEL_W-1:0] hs_sel;
        logic [SG_SEL_W-1:0] vs_sel;
    } gen_cfg_t;

    typedef enum logic [1:0] {
        PH_OFFSET = 2'd0,
        PH_RUN    = 2'd1,
        PH_DONE   = 2'd2
    } phase_e;

    function automatic logic src_hit(input logic [SG_SRC_W-1:0] code,
                                     input logic [SG_NSRC-1:0]  ev);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < SG_NSRC; i++) begin
            if (int'(code) == i) hit = ev[i];
        end
        return hit;
    endfunction

    function automatic logic slot_over(input logic [15:0] v, input int w);
        return (int'(v) >> w) != 0;
    endfunction

endpackage

// File: rtl/sync_cfg_regs.sv
module sync_cfg_regs
    import sync_gen_pkg::*;
(
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          cfg_we_i,
    input  logic [SG_ADDR_W-1:0]          cfg_addr_i,
    input  logic [SG_DATA_W-1:0]          cfg_wdata_i,
    output ctr_cfg_t [SG_NCTR-1:0]        ctr_cfg_o,
    output gen_cfg_t                      gen_cfg_o
);

    localparam logic [SG_DATA_W-1:0] GEN_MASK =
        ((SG_DATA_W'(1) << SG_NCTR) - 1) |
        (((SG_DATA_W'(1) << SG_SEL_W) - 1) << 8) |
        (((SG_DATA_W'(1) << SG_SEL_W) - 1) << 12);

    typedef struct packed {
        ctr_cfg_t [SG_NCTR-1:0] ctr;
        gen_cfg_t               gen;
    } regs_t;

    regs_t r_d, r_q;
    logic [SG_SEL_W-1:0] idx;
    logic w0_bad, w1_bad, w2_bad, gen_bad;

    always_comb begin
        r_d = r_q;
        idx = cfg_addr_i[2 +: SG_SEL_W];
        w0_bad  = slot_over(cfg_wdata_i[15:0], SG_RUN_W) ||
                  slot_over(cfg_wdata_i[31:16], SG_RUN_W);
        w1_bad  = (|cfg_wdata_i[31:29]) ||
                  (int'(cfg_wdata_i[19:16]) >= SG_NSRC) ||
                  (int'(cfg_wdata_i[23:20]) >= SG_NSRC) ||
                  (int'(cfg_wdata_i[27:24]) >= SG_NSRC);
        w2_bad  = slot_over(cfg_wdata_i[15:0], SG_EDGE_W) ||
                  slot_over(cfg_wdata_i[31:16], SG_EDGE_W);
        gen_bad = (cfg_wdata_i & ~GEN_MASK) != '0;
        if (cfg_we_i) begin
            if (int'(cfg_addr_i) == SG_GEN_ADDR) begin
                if (!gen_bad) begin
                    r_d.gen.inv    = cfg_wdata_i[SG_NCTR-1:0];
                    r_d.gen.hs_sel = cfg_wdata_i[8 +: SG_SEL_W];
                    r_d.gen.vs_sel = cfg_wdata_i[12 +: SG_SEL_W];
                end
            end else if (int'(cfg_addr_i) < SG_GEN_ADDR) begin
                case (cfg_addr_i[1:0])
                    2'd0: if (!w0_bad) begin
                        r_d.ctr[idx].run_cnt = cfg_wdata_i[SG_RUN_W-1:0];
                        r_d.ctr[idx].off_cnt = cfg_wdata_i[16 +: SG_RUN_W];
                    end
                    2'd1: if (!w1_bad) begin
                        r_d.ctr[idx].rep_cnt = cfg_wdata_i[SG_REP_W-1:0];
                        r_d.ctr[idx].run_src = cfg_wdata_i[16 +: SG_SRC_W];
                        r_d.ctr[idx].off_src = cfg_wdata_i[20 +: SG_SRC_W];
                        r_d.ctr[idx].clr_src = cfg_wdata_i[24 +: SG_SRC_W];
                        r_d.ctr[idx].lvl_en  = cfg_wdata_i[28];
                    end
                    2'd2: if (!w2_bad) begin
                        r_d.ctr[idx].up_pos = cfg_wdata_i[SG_EDGE_W-1:0];
                        r_d.ctr[idx].dn_pos = cfg_wdata_i[16 +: SG_EDGE_W];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign ctr_cfg_o = r_q.ctr;
    assign gen_cfg_o = r_q.gen;

endmodule

// File: rtl/sync_wave_counter.sv
module sync_wave_counter
    import sync_gen_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               en_i,
    input  ctr_cfg_t           cfg_i,
    input  logic [SG_NSRC-1:0] ev_i,
    output logic               tick_o,
    output logic               wave_o
);

    typedef struct packed {
        phase_e              ph;
        logic [SG_RUN_W-1:0] off;
        logic [SG_RUN_W-1:0] pos;
        logic [SG_REP_W:0]   reps;
        logic                tick;
        logic                level;
    } st_t;

    localparam st_t ST_RST = '{ph: PH_OFFSET, off: '0, pos: '0, reps: '0,
                               tick: 1'b0, level: 1'b0};

    st_t st_d, st_q;
    logic run_ev, off_ev, clr_ev, reached, step, at_start, at_end;
    logic [SG_RUN_W:0] pos2;
    logic [SG_REP_W:0] reps_n;

    always_comb begin
        run_ev   = src_hit(cfg_i.run_src, ev_i);
        off_ev   = src_hit(cfg_i.off_src, ev_i);
        clr_ev   = src_hit(cfg_i.clr_src, ev_i);
        reached  = (st_q.off == cfg_i.off_cnt);
        step     = run_ev && ((st_q.ph == PH_RUN) ||
                              (st_q.ph == PH_OFFSET && reached));
        at_start = (st_q.pos == '0);
        at_end   = (st_q.pos >= cfg_i.run_cnt);
        pos2     = {st_q.pos, 1'b0};
        reps_n   = st_q.reps + (SG_REP_W+1)'(at_start && cfg_i.rep_cnt != '0);

        st_d      = st_q;
        st_d.tick = 1'b0;
        if (!en_i) begin
            st_d = ST_RST;
        end else if (clr_ev) begin
            st_d = ST_RST;
        end else begin
            if (st_q.ph == PH_OFFSET) begin
                if (!reached) begin
                    if (off_ev) st_d.off = st_q.off + 1'b1;
                end else begin
                    st_d.ph = PH_RUN;
                end
            end
            if (step) begin
                st_d.tick  = at_start;
                st_d.pos   = at_end ? '0 : st_q.pos + 1'b1;
                st_d.reps  = reps_n;
                st_d.level = (pos2 >= (SG_RUN_W+1)'(cfg_i.up_pos)) &&
                             (pos2 <  (SG_RUN_W+1)'(cfg_i.dn_pos));
                if (at_end && cfg_i.rep_cnt != '0 &&
                    reps_n == (SG_REP_W+1)'(cfg_i.rep_cnt)) begin
                    st_d.ph    = PH_DONE;
                    st_d.level = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= ST_RST;
        else         st_q <= st_d;
    end

    assign tick_o = st_q.tick;
    assign wave_o = cfg_i.lvl_en ? st_q.level : st_q.tick;

endmodule

// File: rtl/sync_pin_map.sv
module sync_pin_map
    import sync_gen_pkg::*;
(
    input  logic [SG_NCTR-1:0] wave_i,
    input  gen_cfg_t           gen_i,
    output logic [SG_NCTR-1:0] pin_o,
    output logic               hsync_o,
    output logic               vsync_o
);

    always_comb begin
        pin_o   = wave_i ^ gen_i.inv;
        hsync_o = pin_o[gen_i.hs_sel];
        vsync_o = pin_o[gen_i.vs_sel];
    end

endmodule

// File: rtl/sync_wave_gen.sv
module sync_wave_gen
    import sync_gen_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 en_i,
    input  logic                 pix_tick_i,
    input  logic                 cfg_we_i,
    input  logic [SG_ADDR_W-1:0] cfg_addr_i,
    input  logic [SG_DATA_W-1:0] cfg_wdata_i,
    output logic [SG_NCTR-1:0]   wave_o,
    output logic [SG_NCTR-1:0]   pin_o,
    output logic                 hsync_o,
    output logic                 vsync_o
);

    ctr_cfg_t [SG_NCTR-1:0] cfg_w;
    gen_cfg_t               gen_w;
    logic [SG_NCTR-1:0]     tick_w;
    logic [SG_NSRC-1:0]     ev_w;

    assign ev_w = {tick_w, pix_tick_i, 1'b0};

    sync_cfg_regs u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cfg_we_i    (cfg_we_i),
        .cfg_addr_i  (cfg_addr_i),
        .cfg_wdata_i (cfg_wdata_i),
        .ctr_cfg_o   (cfg_w),
        .gen_cfg_o   (gen_w)
    );

    for (genvar k = 0; k < SG_NCTR; k++) begin : g_ctr
        sync_wave_counter u_ctr (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .en_i   (en_i),
            .cfg_i  (cfg_w[k]),
            .ev_i   (ev_w),
            .tick_o (tick_w[k]),
            .wave_o (wave_o[k])
        );
    end

    sync_pin_map u_pins (
        .wave_i  (wave_o),
        .gen_i   (gen_w),
        .pin_o   (pin_o),
        .hsync_o (hsync_o),
        .vsync_o (vsync_o)
    );

endmodule

// File: rtl/sync_wave_gen_chk.sv
module sync_wave_gen_chk
    import sync_gen_pkg::*;
(
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic                   en_i,
    input logic                   cfg_we_i,
    input logic [SG_ADDR_W-1:0]   cfg_addr_i,
    input logic [SG_DATA_W-1:0]   cfg_wdata_i,
    input logic [SG_NCTR-1:0]     wave_o,
    input logic [SG_NCTR-1:0]     tick_w,
    input logic [SG_NSRC-1:0]     ev_w,
    input ctr_cfg_t [SG_NCTR-1:0] cfg_w
);

    AST_QUIET_WHEN_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (wave_o == '0) && (tick_w == '0)); // R9

    for (genvar k = 0; k < SG_NCTR; k++) begin : g_chk
        logic clr_hit;
        assign clr_hit = src_hit(cfg_w[k].clr_src, ev_w);

        AST_NO_SOURCE_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($past(cfg_w[k].run_src) == '0) |-> !tick_w[k]); // R10

        AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            en_i && clr_hit |=> !tick_w[k] && !wave_o[k]); // R5

        AST_RUN_WORD_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
            cfg_we_i && (int'(cfg_addr_i) == 4 * k) &&
            (slot_over(cfg_wdata_i[15:0], SG_RUN_W) || slot_over(cfg_wdata_i[31:16], SG_RUN_W))
            |=> $stable(cfg_w[k].run_cnt) && $stable(cfg_w[k].off_cnt)); // R8

        AST_EDGE_WORD_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
            cfg_we_i && (int'(cfg_addr_i) == 4 * k + 2) &&
            (slot_over(cfg_wdata_i[15:0], SG_EDGE_W) || slot_over(cfg_wdata_i[31:16], SG_EDGE_W))
            |=> $stable(cfg_w[k].up_pos) && $stable(cfg_w[k].dn_pos)); // R8
    end

endmodule

bind sync_wave_gen sync_wave_gen_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .wave_o      (wave_o),
    .tick_w      (tick_w),
    .ev_w        (ev_w),
    .cfg_w       (cfg_w)
);

// File: tb/tb_sync_wave_gen.sv
`timescale 1ns/1ps
module tb_sync_wave_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        pix = 1'b0;
    logic        we = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [7:0]  wave, pin;
    logic        hs, vs;

    sync_wave_gen dut (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .pix_tick_i(pix),
        .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
        .wave_o(wave), .pin_o(pin), .hsync_o(hs), .vsync_o(vs)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int         at;
        logic [7:0] wave;
        logic [7:0] pin;
        logic       hs;
        logic       vs;
        string      tag;
    } exp_t;

    exp_t  sb_q[$];
    int    n_chk = 0;
    int    n_err = 0;
    string bit_tag[8] = '{"R1", "R6", "R2", "R3", "R4", "R5", "R10", "R6"};

    task automatic chk(string req, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_err++;
            $display("FAIL %s cycle=%0d actual=%0h expected=%0h", req, cyc, act, expv);
        end
    endtask

    // monitor: pops expected items when their cycle arrives
    always @(negedge clk) begin : mon
        exp_t e;
        while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
            e = sb_q.pop_front();
            if (e.at < cyc) begin
                chk({e.tag, " missed"}, cyc, e.at);
            end else begin
                for (int k = 0; k < 8; k++)
                    chk((e.tag != "") ? e.tag : bit_tag[k], int'(wave[k]), int'(e.wave[k]));
                chk("R7 pins", int'(pin), int'(e.pin));
                chk("R7 hsync", int'(hs), int'(e.hs));
                chk("R7 vsync", int'(vs), int'(e.vs));
            end
        end
    end

    function automatic logic [7:0] model(int t, bit c6_on);
        logic [7:0] w;
        int m = t % 10;
        w[0] = (m == 0);
        w[1] = (m <= 2);
        w[2] = (t >= 1) && ((t - 1) % 30 == 0);
        w[3] = (t >= 5) && ((t - 5) % 4 == 0);
        w[4] = (t == 0) || (t == 2) || (t == 4);
        w[5] = (m >= 4) && (m <= 7);
        w[6] = c6_on;
        w[7] = (m >= 3) && (m <= 5);
        return w;
    endfunction

    function automatic logic [31:0] w1(int rep, int rs, int os, int cs, int lv);
        return (32'(lv) << 28) | (32'(cs) << 24) | (32'(os) << 20) | (32'(rs) << 16) | 32'(rep);
    endfunction

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = 6'(a); wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic push_one(int at, logic [7:0] w, logic [7:0] inv, string tag);
        exp_t e;
        logic [7:0] p;
        p = w ^ inv;
        e.at = at; e.wave = w; e.pin = p; e.hs = p[1]; e.vs = p[7]; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic run_window(int n, bit c6_on, string tag);
        int c0;
        @(negedge clk);
        en = 1'b1;
        c0 = cyc + 1;
        for (int t = 0; t < n; t++) push_one(c0 + t, model(t, c6_on), 8'h80, tag);
        repeat (n + 2) @(negedge clk);
    endtask

    task automatic stop_run();
        @(negedge clk);
        en = 1'b0;
        push_one(cyc + 1, 8'h00, 8'h80, "R9");   // R9: quiet one edge after disable
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        pix = 1'b1;
        push_one(cyc + 1, 8'h00, 8'h00, "R9");    // R9: reset state, mask cleared
        repeat (2) @(negedge clk);

        // counter 0: line tick, period 10 (R1)
        wr(0, {16'd0, 16'd9});   wr(1, w1(0, 1, 0, 0, 0));
        // counter 1: level, up 0 down 6 (R6)
        wr(4, {16'd0, 16'd9});   wr(5, w1(0, 1, 0, 0, 1)); wr(6, {16'd6, 16'd0});
        // counter 2: chained on counter 0, period 3 (R2)
        wr(8, {16'd0, 16'd2});   wr(9, w1(0, 2, 0, 0, 0));
        // counter 3: offset 5 pixel events, period 4 (R3)
        wr(12, {16'd5, 16'd3});  wr(13, w1(0, 1, 1, 0, 0));
        // counter 4: repeat limit 3, period 2 (R4)
        wr(16, {16'd0, 16'd1});  wr(17, w1(3, 1, 0, 0, 0));
        // counter 5: offset 2, repeat 4, cleared by counter 0 (R5)
        wr(20, {16'd2, 16'd0});  wr(21, w1(4, 1, 1, 2, 0));
        // counter 6 left with no step source (R10)
        // counter 7: level, up 5 down 12 (R6)
        wr(28, {16'd0, 16'd9});  wr(29, w1(0, 1, 0, 0, 1)); wr(30, {16'd12, 16'd5});
        // general word: invert output 7, hsync <- 1, vsync <- 7 (R7)
        wr(32, 32'h0000_7180);

        run_window(70, 1'b0, "");
        stop_run();

        // R8: rejected words must change nothing
        wr(0, {16'd0, 16'h1000});                  // run out of range
        wr(6, {16'h0400, 16'd0});                  // down out of range
        wr(25, w1(0, 1, 0, 12, 0));                // clear code above 9
        wr(25, w1(0, 1, 0, 0, 0) | 32'h8000_0000); // reserved bit set
        run_window(40, 1'b0, "R8");
        stop_run();

        // R8: a valid word enables counter 6 on every pixel tick
        wr(25, w1(0, 1, 0, 0, 0));
        run_window(20, 1'b1, "R8");
        stop_run();

        repeat (4) @(negedge clk);
        if (sb_q.size() != 0) chk("R9 queue drained", sb_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule